// File: doc/BRIEF.md
# Windowed register access bridge

This block carries single register reads and writes from a requester to a device register bus whose address space is only partly visible at one time. The low part of the offset space, up to a fixed aperture limit, is always reachable at its own address. Offsets at or above that limit are reached through a movable window. The bridge first writes a window-select register with the upper offset bits. It then performs the real access inside a fixed window region whose base sits at the aperture limit.

The bridge remembers which window it last programmed. When a later access falls in the same window, it skips the select write and issues only the data access. A static enable input turns windowing off. In that case every offset, however large, goes to the bus unchanged.

The requester starts an access with a one-cycle strobe while the bridge is idle. It then waits for a one-cycle done pulse, which comes with the read data. The bus side uses a valid/ready handshake. The bridge holds a transaction steady until the bus accepts it.

Top module: `regwin_bridge`

## Requirements
- R1: While and after reset, `busy`, `done` and `bus_valid` are 0 and `rdata` is 0. No window counts as programmed.
- R2: With `win_en` = 1, an offset below 0x80000 produces exactly one bus transaction, at `bus_addr` equal to the offset, with no select write before it.
- R3: With `win_en` = 0, every offset, including those at or above 0x80000, produces exactly one bus transaction at the unchanged offset. Such an access leaves the remembered window as it was.
- R4: With `win_en` = 1 and an offset at or above 0x80000, the window number is offset bits [23:19]. When a select write is needed, it is a write to address 0x310C with data 0x8000_0000 OR the window number. It is followed directly by the data access at address 0x80000 OR offset bits [18:0].
- R5: The select write is left out when the window number equals the one last written by a completed select write. The first windowed access after reset always performs it.
- R6: Reads and writes follow the same sequence. `bus_write` carries the access direction and `bus_wdata` carries the write data. On a read, `rdata` shows the bus read data together with `done`. `rdata` keeps that value until the next read completes.
- R7: `busy` is 1 from the cycle after a request is accepted until the data transaction's handshake. `done` is a single-cycle pulse in the cycle after that handshake, when `busy` is already 0.
- R8: A `req_valid` strobe while `busy` is 1 is ignored. The current access continues unchanged, and no extra bus transaction follows.
- R9: While `bus_valid` is 1 and `bus_ready` is 0, the bridge holds `bus_valid`, `bus_addr`, `bus_write` and `bus_wdata` stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| win_en | input | 1 | Windowing enable; 0 sends every offset directly |
| req_valid | input | 1 | Request strobe, taken only while idle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_offset | input | 24 | Register byte offset |
| req_wdata | input | 32 | Write data |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 32 | Data of the last completed read |
| bus_valid | output | 1 | Bus transaction present |
| bus_write | output | 1 | Bus transaction direction |
| bus_addr | output | 24 | Bus address |
| bus_wdata | output | 32 | Bus write data |
| bus_ready | input | 1 | Bus accepts the transaction this cycle |
| bus_rdata | input | 32 | Bus read data, valid with `bus_ready` |

## Verification
The bench builds the bridge with its default parameters. These are a 24-bit offset, a window field of 5 bits starting at bit 19, and the select register at 0x310C. With these values, windows 1 through 31 can be reached, including the topmost offset 0xFFFFFF, alongside the direct region. Random offsets are drawn mostly from three windows, so that cache hits and misses both occur often, and a small share of accesses run with windowing off. Random bus stall lengths exercise the hold rule on both the select and the data transactions.

// File: rtl/regwin_pkg.sv
package regwin_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SEL  = 2'd1,
    ST_ACC  = 2'd2
  } regwin_state_e;
endpackage

// File: rtl/regwin_map.sv
module regwin_map #(
  parameter int OFS_W   = 24,
  parameter int WIN_LSB = 19,
  parameter int WIN_W   = 5
) (
  input  logic [OFS_W-1:0] offset,
  input  logic             win_en,
  output logic             windowed,
  output logic [WIN_W-1:0] win_num,
  output logic [OFS_W-1:0] win_addr
);
  localparam int HI_W = OFS_W - WIN_LSB;

  always_comb begin
    windowed = win_en && (|offset[OFS_W-1:WIN_LSB]);
    win_num  = offset[WIN_LSB +: WIN_W];
    win_addr = {{(HI_W-1){1'b0}}, 1'b1, offset[WIN_LSB-1:0]};
  end
endmodule

// File: rtl/regwin_track.sv
module regwin_track #(
  parameter int WIN_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             upd,
  input  logic [WIN_W-1:0] upd_win,
  input  logic [WIN_W-1:0] cur_win,
  output logic             hit
);
  logic             valid_q;
  logic [WIN_W-1:0] win_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      win_q   <= '0;
    end else if (upd) begin
      valid_q <= 1'b1;
      win_q   <= upd_win;
    end
  end

  assign hit = valid_q && (win_q == cur_win);
endmodule

// File: rtl/regwin_seq.sv
module regwin_seq
  import regwin_pkg::*;
#(
  parameter int OFS_W    = 24,
  parameter int DATA_W   = 32,
  parameter int WIN_W    = 5,
  parameter int WIN_LSB  = 19,
  parameter logic [OFS_W-1:0] SEL_ADDR = 24'h00310C
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [OFS_W-1:0]  req_addr,
  input  logic [WIN_W-1:0]  req_win,
  input  logic              req_need_sel,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rdata,
  output logic              sel_upd,
  output logic [WIN_W-1:0]  sel_win,
  output logic              bus_valid,
  output logic              bus_write,
  output logic [OFS_W-1:0]  bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_ready,
  input  logic [DATA_W-1:0] bus_rdata
);
  localparam logic [OFS_W-1:0] WIN_BASE = OFS_W'(1) << WIN_LSB;

  regwin_state_e     state_q, state_d;
  logic              wr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [OFS_W-1:0]  addr_q;
  logic [WIN_W-1:0]  win_q;
  logic              done_q, done_d;
  logic [DATA_W-1:0] rdata_q;
  logic              accept, rd_en;
  logic [DATA_W-1:0] sel_word;

  assign accept   = (state_q == ST_IDLE) && req_valid;
  assign sel_word = {1'b1, {(DATA_W-1-WIN_W){1'b0}}, win_q};

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: if (accept) state_d = req_need_sel ? ST_SEL : ST_ACC;
      ST_SEL:  if (bus_ready) state_d = ST_ACC;
      ST_ACC:  if (bus_ready) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
    done_d = (state_q == ST_ACC) && bus_ready;
    rd_en  = done_d && !wr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q    <= 1'b0;
      wdata_q <= '0;
      addr_q  <= '0;
      win_q   <= '0;
    end else if (accept) begin
      wr_q    <= req_write;
      wdata_q <= req_wdata;
      addr_q  <= req_addr;
      win_q   <= req_win;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata_q <= '0;
    else if (rd_en) rdata_q <= bus_rdata;
  end

  always_comb begin
    bus_valid = (state_q != ST_IDLE);
    bus_write = (state_q == ST_SEL) ? 1'b1 : wr_q;
    bus_addr  = (state_q == ST_SEL) ? SEL_ADDR : addr_q;
    bus_wdata = (state_q == ST_SEL) ? sel_word : wdata_q;
    sel_upd   = (state_q == ST_SEL) && bus_ready;
    sel_win   = win_q;
    busy      = (state_q != ST_IDLE);
    done      = done_q;
    rdata     = rdata_q;
  end

  AST_BUS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_ready) |=> (bus_valid && $stable(bus_addr) && $stable(bus_write) && $stable(bus_wdata))); // R9
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R7
  AST_DONE_AFTER_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(bus_valid && bus_ready) && !busy)); // R7
  AST_SEL_THEN_ACC: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_ready && bus_addr == SEL_ADDR && state_q == ST_SEL) |=> (bus_valid && bus_addr >= WIN_BASE)); // R4
endmodule

// File: rtl/regwin_bridge.sv
module regwin_bridge #(
  parameter int OFS_W    = 24,
  parameter int DATA_W   = 32,
  parameter int WIN_W    = 5,
  parameter int WIN_LSB  = 19,
  parameter logic [OFS_W-1:0] SEL_ADDR = 24'h00310C
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              win_en,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [OFS_W-1:0]  req_offset,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rdata,
  output logic              bus_valid,
  output logic              bus_write,
  output logic [OFS_W-1:0]  bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_ready,
  input  logic [DATA_W-1:0] bus_rdata
);
  logic             windowed, hit, need_sel, sel_upd;
  logic [WIN_W-1:0] win_num, sel_win;
  logic [OFS_W-1:0] win_addr, tgt_addr;

  regwin_map #(.OFS_W(OFS_W), .WIN_LSB(WIN_LSB), .WIN_W(WIN_W)) u_map (
    .offset(req_offset), .win_en(win_en), .windowed(windowed),
    .win_num(win_num), .win_addr(win_addr)
  );

  regwin_track #(.WIN_W(WIN_W)) u_track (
    .clk(clk), .rst_n(rst_n), .upd(sel_upd), .upd_win(sel_win),
    .cur_win(win_num), .hit(hit)
  );

  assign need_sel = windowed && !hit;
  assign tgt_addr = windowed ? win_addr : req_offset;

  regwin_seq #(.OFS_W(OFS_W), .DATA_W(DATA_W), .WIN_W(WIN_W),
               .WIN_LSB(WIN_LSB), .SEL_ADDR(SEL_ADDR)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_write(req_write), .req_wdata(req_wdata),
    .req_addr(tgt_addr), .req_win(win_num), .req_need_sel(need_sel),
    .busy(busy), .done(done), .rdata(rdata),
    .sel_upd(sel_upd), .sel_win(sel_win),
    .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_ready(bus_ready), .bus_rdata(bus_rdata)
  );

  AST_HIT_SKIPS_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !busy && windowed && hit) |=> (bus_valid && bus_addr != SEL_ADDR)); // R5
  AST_DIRECT_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !busy && !windowed) |=> (bus_valid && bus_addr == $past(req_offset))); // R2
endmodule

// File: tb/regwin_bridge_tb.sv
module regwin_bridge_tb_top;
  logic        clk, rst_n, win_en, req_valid, req_write;
  logic [23:0] req_offset;
  logic [31:0] req_wdata;
  logic        busy, done, bus_valid, bus_write, bus_ready;
  logic [31:0] rdata, bus_wdata, bus_rdata;
  logic [23:0] bus_addr;

  int n_chk = 0;
  int n_err = 0;
  bit m_valid = 0;
  logic [4:0]  m_win = '0;
  logic [31:0] m_rd = '0;
  bit finished = 0;

  regwin_bridge dut_i (
    .clk(clk), .rst_n(rst_n), .win_en(win_en), .req_valid(req_valid),
    .req_write(req_write), .req_offset(req_offset), .req_wdata(req_wdata),
    .busy(busy), .done(done), .rdata(rdata), .bus_valid(bus_valid),
    .bus_write(bus_write), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_ready(bus_ready), .bus_rdata(bus_rdata)
  );

  initial clk = 0;
  always #10 clk = ~clk;

  function automatic logic [31:0] pat(input logic [23:0] a);
    return {8'hC3, a} ^ 32'h0015_A5A5;
  endfunction

  function automatic logic [23:0] map_addr(input logic [23:0] o, input bit w);
    return w ? (24'h080000 | {5'd0, o[18:0]}) : o;
  endfunction

  task automatic check(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", rq, act, exp);
    end
  endtask

  task automatic bus_xact(input bit w, input logic [23:0] a, input logic [31:0] d,
                          input string rq, input bit poke);
    int n;
    check(rq, {31'd0, bus_valid}, 32'd1);
    check(rq, {8'd0, bus_addr}, {8'd0, a});
    check(rq, {31'd0, bus_write}, {31'd0, w});
    if (w) check(rq, bus_wdata, d);
    n = int'($urandom % 3) + (poke ? 1 : 0);
    for (int i = 0; i < n; i++) begin
      if (poke && i == 0) begin
        req_valid = 1; req_write = ~req_write; req_offset = 24'h000040;
      end
      @(posedge clk); @(negedge clk);
      req_valid = 0;
      check("R9", {8'd0, bus_addr}, {8'd0, a});
      check("R9", {31'd0, bus_valid}, 32'd1);
    end
    bus_ready = 1; bus_rdata = pat(a);
    @(posedge clk); @(negedge clk);
    bus_ready = 0; bus_rdata = 32'hDEAD_BEEF;
  endtask

  task automatic do_req(input bit wr, input logic [23:0] ofs, input logic [31:0] wd,
                        input bit poke);
    bit wnd, need;
    logic [4:0] win;
    logic [23:0] a;
    wnd  = win_en && (ofs >= 24'h080000);
    win  = ofs[23:19];
    need = wnd && (!m_valid || m_win != win);
    a    = map_addr(ofs, wnd);
    @(negedge clk);
    req_valid = 1; req_write = wr; req_offset = ofs; req_wdata = wd;
    @(posedge clk); @(negedge clk);
    req_valid = 0;
    check("R7", {31'd0, busy}, 32'd1);
    if (need) begin
      bus_xact(1'b1, 24'h00310C, 32'h8000_0000 | {27'd0, win}, "R4", poke);
      m_valid = 1; m_win = win;
      poke = 0;
    end
    bus_xact(wr, a, wd, wnd ? "R4" : (win_en ? "R2" : "R3"), poke);
    if (!wr) m_rd = pat(a);
    check("R7", {30'd0, done, busy}, 32'd2);
    check("R6", rdata, m_rd);
    @(negedge clk);
    check("R7", {31'd0, done}, 32'd0);
    check("R8", {31'd0, bus_valid}, 32'd0);
  endtask

  initial begin
    void'($urandom(32'h5EED_0042));
    rst_n = 0; win_en = 1; req_valid = 0; req_write = 0; req_offset = '0;
    req_wdata = '0; bus_ready = 0; bus_rdata = '0;
    repeat (3) @(negedge clk);
    check("R1", {29'd0, busy, done, bus_valid}, 32'd0);
    check("R1", rdata, 32'd0);
    rst_n = 1;
    @(negedge clk);
    check("R1", {29'd0, busy, done, bus_valid}, 32'd0);
    // R2 direct accesses, including the select register address itself
    do_req(0, 24'h000040, 32'h0, 0);
    do_req(1, 24'h00310C, 32'h1234_5678, 0);
    // R5 first windowed access after reset selects, same window skips
    do_req(0, 24'h1A2345, 32'h0, 0);
    do_req(1, 24'h1F0004, 32'hCAFE_0001, 0);
    do_req(0, 24'hFFFFFF, 32'h0, 0);
    // R3 windowing off: direct, cache untouched
    win_en = 0;
    do_req(0, 24'h093000, 32'h0, 0);
    do_req(1, 24'h3FFFF0, 32'h55AA_55AA, 0);
    win_en = 1;
    do_req(0, 24'hF80010, 32'h0, 0);
    // R8 strobe while busy, on a select sequence and a direct one
    do_req(1, 24'h0A0000, 32'h0BAD_F00D, 1);
    do_req(0, 24'h000100, 32'h0, 1);
    // R6 random mix
    for (int k = 0; k < 400; k++) begin
      logic [23:0] o;
      int sel;
      sel = int'($urandom % 8);
      o = $urandom;
      if (sel < 5) o[23:19] = 5'(sel % 3 + 1);
      else if (sel == 5) o = {5'd0, o[18:0]};
      win_en = ($urandom % 10) != 0;
      do_req($urandom % 2, o, $urandom, ($urandom % 8) == 0);
    end
    win_en = 1;
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_err++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
      $finish;
    end
  end
endmodule